// File: doc/BRIEF.md
# Trap and Interrupt Control Coprocessor

This block is the exception-control coprocessor of a small 32-bit RISC core. It holds four architectural registers: a status word, a cause word, the saved return address and the faulting data address. It watches three sources of control transfer. The first is synchronous faults reported by the pipeline together with the PC of the faulting instruction and the faulting data address. The second is a bank of external interrupt lines. The third is the return-from-exception strobe. When an event is accepted, the block records what happened and asks the fetch stage, one cycle later, to restart at a single fixed kernel entry address.

Interrupt lines are sampled every cycle into the pending field of the cause word. This happens whether or not they are masked, so software can poll them. An interrupt is only accepted when all of the following hold: the global enable is on, the core is not already in exception level, and some pending line is unmasked. A return-from-exception leaves exception level and redirects fetch to the saved return address. Software reaches the registers through a single read/write port, which is driven by the move-to and move-from instructions.

Top module: `trap_unit`

## Requirements
- R1: After reset, the status (index 12), cause (index 13), return-address (index 14) and bad-address (index 8) registers read zero, and redirectValid is low.
- R2: A synchronous fault request (excReq) accepted at a clock edge raises redirectValid for exactly the following cycle, with redirectPc = 0x80000180. It sets status bit 1 (exception level). If that bit was clear before the edge, it also stores excPc into the return-address register.
- R3: An accepted event writes its 5-bit code into cause bits 6..2: excCode for a fault, 0 for an interrupt. The other cause bits outside the pending field read zero, so a fault with code 12 and no pending lines reads cause = 0x00000030.
- R4: A fault with code 4 stores excAddr into the bad-address register. A fault with any other code leaves that register unchanged.
- R5: Cause bits 8+i mirror irqLines[i] one cycle after they are sampled, whatever the mask, enable and exception-level state.
- R6: An interrupt is accepted only when status bit 0 is 1, status bit 1 is 0, and some cause bit 8+i is set together with status bit 8+i. On acceptance it redirects to 0x80000180, stores resumePc as the return address, writes code 0 and sets status bit 1.
- R7: When a fault request and an acceptable interrupt occur in the same cycle, the fault is taken and its excPc is saved.
- R8: While status bit 1 is set, no interrupt is accepted. A fault in that state still redirects and updates the code and bad address, but the return address is kept.
- R9: An eretReq accepted at an edge redirects fetch for the following cycle to the return address held at that edge, and clears status bit 1.
- R10: Software writes (regWrEn) change only status bits 15..8, 1 and 0, and the whole return-address register. Writes to the cause and bad-address registers are ignored. A write in the same cycle as an accepted fault, interrupt or return is dropped.
- R11: Reads of any register index other than 8, 12, 13 and 14 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Synchronous fault request this cycle |
| excCode | input | 5 | Fault type code |
| excPc | input | 32 | PC of the faulting instruction |
| excAddr | input | 32 | Faulting data address |
| resumePc | input | 32 | PC saved when an interrupt is accepted |
| irqLines | input | 8 | External interrupt request lines |
| eretReq | input | 1 | Return-from-exception strobe |
| regAddr | input | 5 | Register index for read and write |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| redirectValid | output | 1 | Fetch redirect request |
| redirectPc | output | 32 | Fetch redirect target |

## Verification
The bench sweeps all 32 fault codes with a return after each one. A design that wrote the bad address for every code, or put the code in the wrong bits, fails that sweep. It also sweeps all 256 interrupt-line patterns with the mask closed, which catches a pending field that is gated by the mask, and sweeps each line against its own mask bit and a neighbouring one, which catches an acceptance term that ignores the mask. Collision cases cover three situations: a fault and an interrupt in the same cycle, where the wrong priority saves resumePc; a second fault under exception level, where a missing guard overwrites the return address; and a software write in the same cycle as a fault, where the write wins.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [4:0] CODE_IRQ  = 5'd0;
  localparam logic [4:0] CODE_ADDR = 5'd4;
  localparam logic [4:0] CODE_OVF  = 5'd12;

  localparam logic [4:0] IDX_VADDR  = 5'd8;
  localparam logic [4:0] IDX_STATUS = 5'd12;
  localparam logic [4:0] IDX_CAUSE  = 5'd13;
  localparam logic [4:0] IDX_EPC    = 5'd14;

  localparam int FIELD_LO = 8;  // mask and pending fields start here
  localparam int CODE_LO  = 2;

  typedef struct packed {
    logic takeExc;
    logic takeIrq;
    logic doEret;
    logic doWrite;
  } trapStrb_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             excReq,
  input  logic             eretReq,
  input  logic             regWrEn,
  input  logic             exlBit,
  input  logic             ieBit,
  input  logic [IRQ_W-1:0] pendVec,
  input  logic [IRQ_W-1:0] maskVec,
  output trapStrb_t        strb
);
  logic irqLive;

  // an interrupt is only eligible outside exception level with enable on
  assign irqLive = ieBit && !exlBit && (|(pendVec & maskVec));

  always_comb begin
    strb         = '0;
    strb.takeExc = excReq;
    strb.takeIrq = !excReq && irqLive;
    strb.doEret  = eretReq && !excReq && !irqLive;
    strb.doWrite = regWrEn && !(strb.takeExc || strb.takeIrq || strb.doEret);
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          IRQ_W  = 8,
  parameter logic [31:0] VECTOR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trapStrb_t         strb,
  input  logic [4:0]        excCode,
  input  logic [DATA_W-1:0] excPc,
  input  logic [DATA_W-1:0] excAddr,
  input  logic [DATA_W-1:0] resumePc,
  input  logic [IRQ_W-1:0]  irqLines,
  input  logic [4:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              redirectValid,
  output logic [DATA_W-1:0] redirectPc,
  output logic              exlBit,
  output logic              ieBit,
  output logic [IRQ_W-1:0]  pendVec,
  output logic [IRQ_W-1:0]  maskVec,
  output logic [DATA_W-1:0] epcVal,
  output logic [4:0]        causeCode
);
  localparam int FIELD_HI = FIELD_LO + IRQ_W - 1;

  logic [IRQ_W-1:0]  maskR, pendR;
  logic              exlR, ieR, redirV;
  logic [4:0]        codeR;
  logic [DATA_W-1:0] epcR, vaddrR, redirPcR;
  logic [DATA_W-1:0] statusWord, causeWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskR    <= '0;
      pendR    <= '0;
      exlR     <= 1'b0;
      ieR      <= 1'b0;
      codeR    <= '0;
      epcR     <= '0;
      vaddrR   <= '0;
      redirV   <= 1'b0;
      redirPcR <= '0;
    end else begin
      pendR  <= irqLines;
      redirV <= 1'b0;
      if (strb.takeExc) begin
        codeR    <= excCode;
        exlR     <= 1'b1;
        redirV   <= 1'b1;
        redirPcR <= VECTOR[DATA_W-1:0];
        if (!exlR) epcR <= excPc;
        if (excCode == CODE_ADDR) vaddrR <= excAddr;
      end else if (strb.takeIrq) begin
        codeR    <= CODE_IRQ;
        exlR     <= 1'b1;
        epcR     <= resumePc;
        redirV   <= 1'b1;
        redirPcR <= VECTOR[DATA_W-1:0];
      end else if (strb.doEret) begin
        exlR     <= 1'b0;
        redirV   <= 1'b1;
        redirPcR <= epcR;
      end else if (strb.doWrite) begin
        case (regAddr)
          IDX_STATUS: begin
            maskR <= regWrData[FIELD_HI:FIELD_LO];
            exlR  <= regWrData[1];
            ieR   <= regWrData[0];
          end
          IDX_EPC: epcR <= regWrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    statusWord                    = '0;
    statusWord[FIELD_HI:FIELD_LO] = maskR;
    statusWord[1]                 = exlR;
    statusWord[0]                 = ieR;
    causeWord                     = '0;
    causeWord[FIELD_HI:FIELD_LO]  = pendR;
    causeWord[CODE_LO +: 5]       = codeR;
  end

  always_comb begin
    case (regAddr)
      IDX_VADDR:  regRdData = vaddrR;
      IDX_STATUS: regRdData = statusWord;
      IDX_CAUSE:  regRdData = causeWord;
      IDX_EPC:    regRdData = epcR;
      default:    regRdData = '0;
    endcase
  end

  assign redirectValid = redirV;
  assign redirectPc    = redirPcR;
  assign exlBit        = exlR;
  assign ieBit         = ieR;
  assign pendVec       = pendR;
  assign maskVec       = maskR;
  assign epcVal        = epcR;
  assign causeCode     = codeR;
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          IRQ_W  = 8,   // at most 8: pending field spans bits 8..15
  parameter logic [31:0] VECTOR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              excReq,
  input  logic [4:0]        excCode,
  input  logic [DATA_W-1:0] excPc,
  input  logic [DATA_W-1:0] excAddr,
  input  logic [DATA_W-1:0] resumePc,
  input  logic [IRQ_W-1:0]  irqLines,
  input  logic              eretReq,
  input  logic [4:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              redirectValid,
  output logic [DATA_W-1:0] redirectPc
);
  trapStrb_t         strb;
  logic              exlBit, ieBit;
  logic [IRQ_W-1:0]  pendVec, maskVec;
  logic [DATA_W-1:0] epcVal;
  logic [4:0]        causeCode;

  trap_ctrl #(.IRQ_W(IRQ_W)) u_ctrl (
    .excReq (excReq),
    .eretReq(eretReq),
    .regWrEn(regWrEn),
    .exlBit (exlBit),
    .ieBit  (ieBit),
    .pendVec(pendVec),
    .maskVec(maskVec),
    .strb   (strb)
  );

  trap_regs #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .VECTOR(VECTOR)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .excCode      (excCode),
    .excPc        (excPc),
    .excAddr      (excAddr),
    .resumePc     (resumePc),
    .irqLines     (irqLines),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc),
    .exlBit       (exlBit),
    .ieBit        (ieBit),
    .pendVec      (pendVec),
    .maskVec      (maskVec),
    .epcVal       (epcVal),
    .causeCode    (causeCode)
  );
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
  import trap_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] VECTOR = 32'h8000_0180
) (
  input logic              clk,
  input logic              rst_n,
  input logic              excReq,
  input logic [4:0]        excCode,
  input logic [DATA_W-1:0] excPc,
  input logic              redirectValid,
  input logic [DATA_W-1:0] redirectPc,
  input trapStrb_t         strb,
  input logic              exlBit,
  input logic [DATA_W-1:0] epcVal,
  input logic [4:0]        causeCode
);
  p_vector_exc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    excReq |=> redirectValid && redirectPc == VECTOR[DATA_W-1:0]);

  p_epc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (excReq && !exlBit) |=> epcVal == $past(excPc));

  p_code_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    excReq |=> causeCode == $past(excCode));

  p_irq_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.takeIrq |=> redirectValid && redirectPc == VECTOR[DATA_W-1:0]
                     && causeCode == CODE_IRQ && exlBit);

  p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.takeExc, strb.takeIrq, strb.doEret}));

  p_exl_blocks_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exlBit |-> !strb.takeIrq);

  p_epc_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (excReq && exlBit) |=> $stable(epcVal));

  p_eret_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doEret |=> redirectValid && redirectPc == $past(epcVal) && !exlBit);
endmodule

bind trap_unit trap_unit_chk #(.DATA_W(DATA_W), .VECTOR(VECTOR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .excReq       (excReq),
  .excCode      (excCode),
  .excPc        (excPc),
  .redirectValid(redirectValid),
  .redirectPc   (redirectPc),
  .strb         (strb),
  .exlBit       (exlBit),
  .epcVal       (epcVal),
  .causeCode    (causeCode)
);

// File: tb/trap_unit_bench.sv
`timescale 1ns/1ps
module trap_unit_bench;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        excReq, eretReq, regWrEn;
  logic [4:0]  excCode, regAddr;
  logic [31:0] excPc, excAddr, resumePc, regWrData, regRdData, redirectPc;
  logic [7:0]  irqLines;
  logic        redirectValid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expVaddr, rd;

  always #4 clk = ~clk;

  trap_unit u_trap_unit (
    .clk(clk), .rst_n(rst_n), .excReq(excReq), .excCode(excCode),
    .excPc(excPc), .excAddr(excAddr), .resumePc(resumePc),
    .irqLines(irqLines), .eretReq(eretReq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic fault(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] ad);
    excReq = 1'b1; excCode = c; excPc = pc; excAddr = ad;
    step();
    excReq = 1'b0;
  endtask

  task automatic doEret();
    eretReq = 1'b1;
    step();
    eretReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    finishRun();
  end

  initial begin
    rst_n = 1'b0; excReq = 0; eretReq = 0; regWrEn = 0;
    excCode = 0; regAddr = 0; excPc = 0; excAddr = 0; resumePc = 0;
    regWrData = 0; irqLines = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 redirectValid", {31'd0, redirectValid}, 32'd0);
    readReg(5'd12, rd); chk("R1 status", rd, 32'd0);
    readReg(5'd13, rd); chk("R1 cause", rd, 32'd0);
    readReg(5'd14, rd); chk("R1 epc", rd, 32'd0);
    step();
    readReg(5'd8, rd); chk("R1 vaddr", rd, 32'd0);

    // R2 R3 R4 R9: every fault code, each followed by a return
    expVaddr = 32'd0;
    for (int c = 0; c < 32; c++) begin
      fault(5'(c), 32'h1000 + 32'(c) * 4, 32'hDEAD_0000 + 32'(c));
      if (c == 4) expVaddr = 32'hDEAD_0004;
      chk("R2 redirect valid", {31'd0, redirectValid}, 32'd1);
      chk("R2 redirect vector", redirectPc, VEC);
      readReg(5'd13, rd); chk("R3 cause code", rd, 32'(c) << 2);
      readReg(5'd14, rd); chk("R2 epc", rd, 32'h1000 + 32'(c) * 4);
      readReg(5'd8, rd);  chk("R4 vaddr", rd, expVaddr);
      step();
      chk("R2 one-cycle pulse", {31'd0, redirectValid}, 32'd0);
      readReg(5'd12, rd); chk("R2 status exl", rd, 32'h2);
      doEret();
      chk("R9 eret valid", {31'd0, redirectValid}, 32'd1);
      chk("R9 eret target", redirectPc, 32'h1000 + 32'(c) * 4);
      readReg(5'd12, rd); chk("R9 exl cleared", rd, 32'h0);
    end

    // R5: pending mirrors lines with mask and enable off
    for (int v = 0; v < 256; v++) begin
      irqLines = 8'(v);
      step();
      readReg(5'd13, rd); chk("R5 pending", rd, (32'(v) << 8) | (32'd31 << 2));
      chk("R5 no take", {31'd0, redirectValid}, 32'd0);
    end
    irqLines = 0;
    // R5 with enable on but mask closed, and with mask open but enable off
    wrReg(5'd12, 32'h1);
    irqLines = 8'hA5; step();
    readReg(5'd13, rd); chk("R5 pending ie only", rd, 32'h0000_A57C);
    step(); chk("R5 masked no take", {31'd0, redirectValid}, 32'd0);
    irqLines = 0;
    wrReg(5'd12, 32'h0000_FF00);
    irqLines = 8'h3C; step();
    readReg(5'd13, rd); chk("R5 pending mask only", rd, 32'h0000_3C7C);
    step(); chk("R5 disabled no take", {31'd0, redirectValid}, 32'd0);
    irqLines = 0; step();

    // R10 software writes, R11 unmapped reads
    wrReg(5'd12, 32'hFFFF_FFFF);
    readReg(5'd12, rd); chk("R10 status writable bits", rd, 32'h0000_FF03);
    wrReg(5'd12, 32'h0);
    readReg(5'd12, rd); chk("R10 status cleared", rd, 32'h0);
    wrReg(5'd13, 32'hFFFF_FFFF);
    readReg(5'd13, rd); chk("R10 cause read-only", rd, 32'h0000_007C);
    wrReg(5'd8, 32'h1234_0000);
    readReg(5'd8, rd); chk("R10 vaddr read-only", rd, expVaddr);
    wrReg(5'd14, 32'h1234_5678);
    readReg(5'd14, rd); chk("R10 epc writable", rd, 32'h1234_5678);
    wrReg(5'd3, 32'hFFFF_FFFF);
    readReg(5'd3, rd); chk("R11 unmapped 3", rd, 32'h0);
    readReg(5'd9, rd); chk("R11 unmapped 9", rd, 32'h0);
    readReg(5'd31, rd); chk("R11 unmapped 31", rd, 32'h0);

    // R6: each line against its own mask bit and a neighbour's
    for (int i = 0; i < 8; i++) begin
      wrReg(5'd12, (32'd1 << (8 + i)) | 32'd1);
      irqLines = 8'd1 << ((i + 1) % 8);
      step(); step(); step();
      chk("R6 other mask no take", {31'd0, redirectValid}, 32'd0);
      readReg(5'd12, rd); chk("R6 exl stays clear", rd, (32'd1 << (8 + i)) | 32'd1);
      irqLines = 0; step();
      irqLines = 8'd1 << i; resumePc = 32'h2000 + 32'(i) * 4;
      step();
      irqLines = 0;
      step();
      chk("R6 irq valid", {31'd0, redirectValid}, 32'd1);
      chk("R6 irq vector", redirectPc, VEC);
      readReg(5'd14, rd); chk("R6 epc resumePc", rd, 32'h2000 + 32'(i) * 4);
      readReg(5'd13, rd); chk("R6 code zero", rd, 32'h0);
      readReg(5'd12, rd); chk("R6 exl set", rd, (32'd1 << (8 + i)) | 32'd3);
      doEret();
      chk("R9 irq return", redirectPc, 32'h2000 + 32'(i) * 4);
      step();
      chk("R6 no retake", {31'd0, redirectValid}, 32'd0);
    end

    // R7: fault and interrupt together
    wrReg(5'd12, 32'h0000_FF01);
    irqLines = 8'h01; step();
    resumePc = 32'h3100; irqLines = 0;
    fault(5'd12, 32'h3000, 32'h0);
    chk("R7 redirect", redirectPc, VEC);
    readReg(5'd14, rd); chk("R7 fault epc wins", rd, 32'h3000);
    readReg(5'd13, rd); chk("R3 overflow cause 0x30", rd, 32'h30);
    doEret();
    chk("R9 return after R7", redirectPc, 32'h3000);

    // R8: exception level holds interrupts and keeps epc
    fault(5'd12, 32'h4000, 32'h0);
    irqLines = 8'h01;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R8 irq held", {31'd0, redirectValid}, 32'd0);
    end
    fault(5'd4, 32'h5000, 32'h0000_BAD0);
    chk("R8 nested fault redirects", {31'd0, redirectValid}, 32'd1);
    readReg(5'd14, rd); chk("R8 epc kept", rd, 32'h4000);
    readReg(5'd8, rd);  chk("R4 nested vaddr", rd, 32'h0000_BAD0);
    readReg(5'd13, rd); chk("R8 code updated", rd, 32'h0000_0110);
    irqLines = 0; step(); step();
    doEret();
    chk("R8 return to first", redirectPc, 32'h4000);
    readReg(5'd12, rd); chk("R9 status after", rd, 32'h0000_FF01);
    step();
    chk("R8 quiet after", {31'd0, redirectValid}, 32'd0);

    // R10: write in same cycle as a fault is dropped
    regWrEn = 1'b1; regAddr = 5'd14; regWrData = 32'h777;
    fault(5'd1, 32'h6000, 32'h0);
    regWrEn = 1'b0;
    readReg(5'd14, rd); chk("R10 write dropped on fault", rd, 32'h6000);
    doEret();
    chk("R9 final return", redirectPc, 32'h6000);

    finishRun();
  end
endmodule